// File: doc/BRIEF.md
# BIST Failure Packet Scan Register

This block is a boundary-scan test data register that reports one failure record from a memory built-in self-test engine. On the rising test clock edge where the TAP controller signals the capture phase, it loads the record into a 100-bit frame in one step. The record holds the per-bit comparator fail flags of four 18-bit memory ports, the 16-bit failing address, the 6-bit controller state and a completion flag. In the shift phase it moves the frame out on the serial output, one bit per test clock, while serial input data enters behind it.

Each frame opens with two 1 bits and closes with two 1 bits. This lets an external reader find the frame boundaries. The completion flag tells the reader what to do next. A 0 means more failures remain, so the self-test must run again to capture the next record. A 1 means this frame carried the last failing record.

The register decodes each cycle into one of three operations: OP_LOAD (capture strobe high; this wins over shift), OP_SHIFT (shift strobe high, capture low) and OP_HOLD (all other strobe combinations, whatever the update strobe does). The register takes OP_LOAD to the loaded frame and OP_SHIFT to the next shift position. OP_HOLD leaves it where it is. The asynchronous test reset takes it to all zeros from any operation.

Top module: `bist_fail_scan_reg`

## Requirements
- R1: On a rising `tck` edge with `capture_dr` high, the register loads the packed frame, and `tdo` shows frame bit 99 after the next falling edge. Capture takes priority when `shift_dr` is high in the same cycle.
- R2: Frame bits 99 and 98 (header) and bits 1 and 0 (trailer) are always 1, so the first two and the last two serial bits of every unloaded frame are 1.
- R3: Frame bits 97 down to 26 carry `fail_flags`, where index p*18+b is data bit b of port p and 1 means a failing bit. `fail_flags[0]` sits at bit 97, so the flags leave least significant index first, straight after the header.
- R4: Frame bits 25 down to 10 carry `fail_addr`, with `fail_addr[15]` at bit 25, so the address leaves most significant bit first, after the flags.
- R5: Frame bits 9 down to 4 carry `bist_state`, with `bist_state[5]` at bit 9, so the state leaves most significant bit first, after the address.
- R6: Frame bit 3 is a constant 0 and frame bit 2 carries `test_done`. They leave in that order, just before the trailer.
- R7: On a rising `tck` edge with `shift_dr` high and `capture_dr` low, the frame moves one place toward bit 99 and `tdi` enters at bit 0. A `tdi` bit therefore appears on `tdo` 100 shifts after it entered.
- R8: `tdo` changes only on falling `tck` edges. Its value just before a rising edge equals its value just after.
- R9: With `capture_dr` and `shift_dr` both low, the register holds its contents and `tdo` stays constant. `update_dr` has no effect.
- R10: While `trst_n` is low, the register and `tdo` are cleared to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| capture_dr | input | 1 | TAP capture-phase strobe for this register |
| shift_dr | input | 1 | TAP shift-phase strobe for this register |
| update_dr | input | 1 | TAP update-phase strobe (no effect on this register) |
| tdi | input | 1 | Serial data in |
| fail_flags | input | 72 | Comparator fail flags; index p*18+b is port p, data bit b |
| fail_addr | input | 16 | Failing memory address |
| bist_state | input | 6 | Self-test controller state |
| test_done | input | 1 | 1 when this is the last failing record |
| tdo | output | 1 | Serial data out, updated on falling `tck` edges |

## Verification
The hardest case to reach from the ports is a cycle where the capture and shift strobes are both high, which a legal TAP sequence never produces. The stimulus drives that combination directly, then unloads the whole frame to confirm that it loaded rather than shifted. A reset that arrives in the middle of an unload is also hard to reach. The stimulus drops the reset between clock edges part way through a frame, checks that the output clears at once, and then unloads a fresh record. To prove the serial length is exactly 100, a known pattern is shifted in behind a frame and then out again.

// File: rtl/bist_fail_scan_pkg.sv
`timescale 1ns/1ps
package bist_fail_scan_pkg;

    // Operation chosen for the register in one test clock cycle
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } scan_op_e;

    // Width of the framing marks at each end of a packet
    localparam int MARK_W = 2;

endpackage

// File: rtl/bfs_op_decode.sv
`timescale 1ns/1ps
module bfs_op_decode
    import bist_fail_scan_pkg::*;
(
    input  logic     capture_dr,
    input  logic     shift_dr,
    input  logic     update_dr,
    output scan_op_e op
);

    // Capture wins over shift; the update strobe never changes the register.
    always_comb begin
        unique case ({capture_dr, shift_dr, update_dr})
            3'b100, 3'b101, 3'b110, 3'b111: op = OP_LOAD;
            3'b010, 3'b011:                 op = OP_SHIFT;
            default:                        op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/bfs_frame_pack.sv
`timescale 1ns/1ps
module bfs_frame_pack
    import bist_fail_scan_pkg::*;
#(
    parameter int FAIL_W  = 72,
    parameter int ADDR_W  = 16,
    parameter int STATE_W = 6,
    localparam int DONE_POS  = MARK_W,
    localparam int SPARE_POS = MARK_W + 1,
    localparam int STATE_LO  = MARK_W + 2,
    localparam int ADDR_LO   = STATE_LO + STATE_W,
    localparam int FAIL_LO   = ADDR_LO + ADDR_W,
    localparam int HEAD_LO   = FAIL_LO + FAIL_W,
    localparam int PKT_W     = HEAD_LO + MARK_W
) (
    input  logic [FAIL_W-1:0]  fail_flags,
    input  logic [ADDR_W-1:0]  fail_addr,
    input  logic [STATE_W-1:0] bist_state,
    input  logic               test_done,
    output logic [PKT_W-1:0]   image
);

    // Framing marks at both ends
    for (genvar m = 0; m < MARK_W; m++) begin : g_mark
        assign image[m]           = 1'b1;
        assign image[HEAD_LO + m] = 1'b1;
    end

    // Fail flags reversed so index 0 sits next to the header (leaves first)
    for (genvar i = 0; i < FAIL_W; i++) begin : g_fail
        assign image[HEAD_LO - 1 - i] = fail_flags[i];
    end

    // Address kept in natural order: its top bit leaves first
    for (genvar a = 0; a < ADDR_W; a++) begin : g_addr
        assign image[ADDR_LO + a] = fail_addr[a];
    end

    // Controller state, top bit leaves first
    for (genvar s = 0; s < STATE_W; s++) begin : g_state
        assign image[STATE_LO + s] = bist_state[s];
    end

    assign image[SPARE_POS] = 1'b0;
    assign image[DONE_POS]  = test_done;

endmodule

// File: rtl/bfs_shift_core.sv
`timescale 1ns/1ps
module bfs_shift_core
    import bist_fail_scan_pkg::*;
#(
    parameter int PKT_W = 100
) (
    input  logic             tck,
    input  logic             trst_n,
    input  scan_op_e         op,
    input  logic [PKT_W-1:0] image,
    input  logic             tdi,
    output logic [PKT_W-1:0] pkt_q
);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            pkt_q <= '0;
        end else begin
            unique case (op)
                OP_LOAD:  pkt_q <= image;
                OP_SHIFT: pkt_q <= {pkt_q[PKT_W-2:0], tdi};
                default:  pkt_q <= pkt_q;
            endcase
        end
    end

endmodule

// File: rtl/bfs_tdo_retime.sv
`timescale 1ns/1ps
module bfs_tdo_retime (
    input  logic tck,
    input  logic trst_n,
    input  logic msb,
    output logic tdo
);

    // Serial output moves on the falling edge, half a cycle after the shift
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) tdo <= 1'b0;
        else         tdo <= msb;
    end

endmodule

// File: rtl/bist_fail_scan_reg.sv
`timescale 1ns/1ps
module bist_fail_scan_reg
    import bist_fail_scan_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 18,
    parameter int ADDR_W    = 16,
    parameter int STATE_W   = 6,
    localparam int FAIL_W   = NUM_PORTS * PORT_W,
    localparam int PKT_W    = 2 * MARK_W + FAIL_W + ADDR_W + STATE_W + 2
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               tdi,
    input  logic [FAIL_W-1:0]  fail_flags,
    input  logic [ADDR_W-1:0]  fail_addr,
    input  logic [STATE_W-1:0] bist_state,
    input  logic               test_done,
    output logic               tdo
);

    scan_op_e         op;
    logic [PKT_W-1:0] image;
    logic [PKT_W-1:0] pkt_q;

    bfs_op_decode u_decode (
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .op         (op)
    );

    bfs_frame_pack #(
        .FAIL_W  (FAIL_W),
        .ADDR_W  (ADDR_W),
        .STATE_W (STATE_W)
    ) u_pack (
        .fail_flags (fail_flags),
        .fail_addr  (fail_addr),
        .bist_state (bist_state),
        .test_done  (test_done),
        .image      (image)
    );

    bfs_shift_core #(
        .PKT_W (PKT_W)
    ) u_core (
        .tck    (tck),
        .trst_n (trst_n),
        .op     (op),
        .image  (image),
        .tdi    (tdi),
        .pkt_q  (pkt_q)
    );

    bfs_tdo_retime u_tdo (
        .tck    (tck),
        .trst_n (trst_n),
        .msb    (pkt_q[PKT_W-1]),
        .tdo    (tdo)
    );

endmodule

// File: rtl/bist_fail_scan_reg_sva.sv
`timescale 1ns/1ps
module bist_fail_scan_reg_sva #(
    parameter int PKT_W  = 100,
    parameter int ADDR_W = 16
) (
    input logic              tck,
    input logic              trst_n,
    input logic              capture_dr,
    input logic              shift_dr,
    input logic              tdi,
    input logic              test_done,
    input logic [ADDR_W-1:0] fail_addr,
    input logic [PKT_W-1:0]  pkt_q,
    input logic              tdo
);

    // R1 R2 R6: after a capture the framing and spare bits hold their fixed values
    a_r2_frame_marks: assert property (@(posedge tck) disable iff (!trst_n)
        capture_dr |=> (pkt_q[PKT_W-1:PKT_W-2] == 2'b11) && (pkt_q[1:0] == 2'b11) && !pkt_q[3]);

    // R6: done flag lands in bit 2
    a_r6_done_bit: assert property (@(posedge tck) disable iff (!trst_n)
        capture_dr |=> pkt_q[2] == $past(test_done));

    // R4: address lands in bits 25..10
    a_r4_addr_field: assert property (@(posedge tck) disable iff (!trst_n)
        capture_dr |=> pkt_q[25:10] == $past(fail_addr));

    // R7: one-place move with serial input at the bottom
    a_r7_shift_step: assert property (@(posedge tck) disable iff (!trst_n)
        (shift_dr && !capture_dr) |=> pkt_q == {$past(pkt_q[PKT_W-2:0]), $past(tdi)});

    // R9: no strobe, no change
    a_r9_hold: assert property (@(posedge tck) disable iff (!trst_n)
        (!shift_dr && !capture_dr) |=> $stable(pkt_q));

    // R8: by each rising edge the output has caught up with the top bit
    a_r8_tdo_tracks_top: assert property (@(posedge tck) disable iff (!trst_n)
        tdo == pkt_q[PKT_W-1]);

    // R10: reset holds everything at zero
    a_r10_reset_clear: assert property (@(posedge tck)
        !trst_n |-> (pkt_q == '0) && !tdo);

endmodule

bind bist_fail_scan_reg bist_fail_scan_reg_sva #(
    .PKT_W  (PKT_W),
    .ADDR_W (ADDR_W)
) u_sva (
    .tck        (tck),
    .trst_n     (trst_n),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .tdi        (tdi),
    .test_done  (test_done),
    .fail_addr  (fail_addr),
    .pkt_q      (pkt_q),
    .tdo        (tdo)
);

// File: tb/bist_fail_scan_reg_bench.sv
`timescale 1ns/1ps
module bist_fail_scan_reg_bench;

    localparam int FAIL_W = 72;
    localparam int PKT_W  = 100;

    logic              tck = 1'b0;
    logic              trst_n = 1'b0;
    logic              capture_dr = 1'b0;
    logic              shift_dr = 1'b0;
    logic              update_dr = 1'b0;
    logic              tdi = 1'b0;
    logic [FAIL_W-1:0] fail_flags = '0;
    logic [15:0]       fail_addr = '0;
    logic [5:0]        bist_state = '0;
    logic              test_done = 1'b0;
    logic              tdo;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  val;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    logic [PKT_W-1:0] m_sr = '0;

    always #2 tck = ~tck;

    bist_fail_scan_reg u_bist_fail_scan_reg (
        .tck        (tck),
        .trst_n     (trst_n),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdi        (tdi),
        .fail_flags (fail_flags),
        .fail_addr  (fail_addr),
        .bist_state (bist_state),
        .test_done  (test_done),
        .tdo        (tdo)
    );

    task automatic check(input bit ok, input string req, input logic act, input logic exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: tdo=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Serial order built from the requirements, then placed so serial bit j is frame bit 99-j
    function automatic logic [PKT_W-1:0] build_frame();
        logic [PKT_W-1:0] f;
        int j;
        j = 0;
        f[PKT_W-1-j] = 1'b1; j++;                                      // R2 header
        f[PKT_W-1-j] = 1'b1; j++;
        for (int i = 0; i < FAIL_W; i++) begin f[PKT_W-1-j] = fail_flags[i]; j++; end // R3
        for (int i = 15; i >= 0; i--) begin f[PKT_W-1-j] = fail_addr[i]; j++; end   // R4
        for (int i = 5; i >= 0; i--) begin f[PKT_W-1-j] = bist_state[i]; j++; end   // R5
        f[PKT_W-1-j] = 1'b0; j++;                                      // R6 spare
        f[PKT_W-1-j] = test_done; j++;                                 // R6 done
        f[PKT_W-1-j] = 1'b1; j++;                                      // R2 trailer
        f[PKT_W-1-j] = 1'b1;
        return f;
    endfunction

    function automatic string tag_for(input int j);
        if (j < 2)   return "R2 header";
        if (j < 74)  return "R3 fail flags";
        if (j < 90)  return "R4 address";
        if (j < 96)  return "R5 state";
        if (j < 98)  return "R6 spare/done";
        return "R2 trailer";
    endfunction

    // Driver: called at rising edge + 1 ns; drives one cycle and pushes the tdo expected
    // after the following falling edge.
    task automatic step(input logic cap, input logic shf, input logic upd,
                        input logic din, input string tag, input bit chk8);
        logic pre, post;
        capture_dr = cap;
        shift_dr   = shf;
        update_dr  = upd;
        tdi        = din;
        if (chk8) begin
            #2.5 pre = tdo;
            @(posedge tck);
            #0.5 post = tdo;
            check(post === pre, "R8 tdo moved at rising edge", post, pre);
            #0.5;
        end else begin
            @(posedge tck);
            #1;
        end
        if (cap)      m_sr = build_frame();
        else if (shf) m_sr = {m_sr[PKT_W-2:0], din};
        exp_q.push_back('{val: m_sr[PKT_W-1], tag: tag});
    endtask

    task automatic unload(input bit capture_with_shift);
        step(1'b1, capture_with_shift, 1'b0, 1'b0,
             capture_with_shift ? "R1 capture wins" : "R1 capture header", 1'b0);
        for (int j = 1; j < PKT_W; j++)
            step(1'b0, 1'b1, 1'b0, 1'b0, tag_for(j), (j % 10) == 5);
    endtask

    // Monitor: compares tdo after every falling edge with the next expected item
    initial begin
        forever begin
            @(negedge tck);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(tdo === e.val, e.tag, tdo, e.val);
            end
        end
    end

    task automatic drain();
        step(1'b0, 1'b0, 1'b0, 1'b0, "R9 idle", 1'b0);
        wait (exp_q.size() == 0);
        @(posedge tck);
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R10: reset state
        #9;
        check(tdo === 1'b0, "R10 reset state", tdo, 1'b0);
        @(negedge tck);
        #1 trst_n = 1'b1;
        @(posedge tck);
        #1;

        // Pattern 1: walking flags per port, done = 0
        for (int i = 0; i < FAIL_W; i++) fail_flags[i] = (i % 18 == 0) || (i == 5) || (i == 70);
        fail_addr  = 16'h8001;
        bist_state = 6'b100110;
        test_done  = 1'b0;
        unload(1'b0);
        drain();

        // Pattern 2: capture with shift also high, hold with update pulses, then unload
        // and shift a pattern through to prove length 100 (R7, R2)
        fail_flags = {FAIL_W{1'b1}};
        fail_addr  = 16'hA5C3;
        bist_state = 6'b011001;
        test_done  = 1'b1;
        step(1'b1, 1'b1, 1'b0, 1'b0, "R1 capture wins", 1'b0);
        for (int k = 0; k < 4; k++)
            step(1'b0, 1'b0, k[0], 1'b1, "R9 hold with update", 1'b1);
        fail_flags = '0;  // inputs change without capture: no effect
        for (int j = 1; j < PKT_W; j++)
            step(1'b0, 1'b1, 1'b0, 1'b0, tag_for(j), 1'b0);
        for (int j = 0; j < PKT_W; j++)
            step(1'b0, 1'b1, 1'b0, ((j * 7) % 3) == 1, "R7 tdi after 100 shifts", 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0, "R7 tdi after 100 shifts", 1'b0);
        drain();

        // Pattern 3: asynchronous reset part way through a frame
        fail_flags = {FAIL_W/2{2'b01}};
        fail_addr  = 16'hFFFF;
        bist_state = 6'b111111;
        test_done  = 1'b0;
        step(1'b1, 1'b0, 1'b0, 1'b1, "R1 capture header", 1'b0);
        for (int j = 1; j < 6; j++)
            step(1'b0, 1'b1, 1'b0, 1'b1, tag_for(j), 1'b0);
        capture_dr = 1'b0;
        shift_dr   = 1'b0;
        wait (exp_q.size() == 0);
        #0.5 trst_n = 1'b0;
        #0.5 check(tdo === 1'b0, "R10 async clear", tdo, 1'b0);
        m_sr = '0;
        @(posedge tck);
        #1 check(tdo === 1'b0, "R10 held in reset", tdo, 1'b0);
        @(negedge tck);
        #1 trst_n = 1'b1;
        @(posedge tck);
        #1;
        step(1'b0, 1'b1, 1'b0, 1'b0, "R10 zero after reset", 1'b0);

        // Pattern 4: fresh record after reset, sparse address
        fail_flags = '0;
        fail_flags[71] = 1'b1;
        fail_addr  = 16'h0010;
        bist_state = 6'b000001;
        test_done  = 1'b1;
        unload(1'b0);
        drain();

        finish_run();
    end

endmodule